// File: doc/BRIEF.md
# Register List Sequencer

This block walks a 16-bit register-list mask, where bit i selects main register i, and hands out the selected register numbers one at a time. A multi-register load or store unit uses it to find the next register to transfer. The mask is captured with a load strobe. After that, each forward strobe returns the lowest register not yet handed out, and each backward strobe returns the highest one not yet handed out. The two directions can be mixed freely.

Internally there are two cursors. A lower bound starts at 0 and an exclusive upper bound starts at 16. The bounds only move toward each other, so no mix of forward and backward steps can return a register twice. Each step takes one cycle, using a priority encoder over the bits that still lie between the two bounds. A returned index is a single-cycle pulse on `idx_o`/`idx_valid_o` and cannot be back-pressured: the requester strobes only when it can take a result. Summary outputs describe the whole captured mask: the set-bit count, an empty flag, the lowest set index, and flags for registers 13, 14 and 15 (stack pointer, link register, program counter).

Top module: `reglist_walker`

## Requirements
- R1: After reset, `idx_valid_o`=0, `done_o`=1, `empty_o`=1, `count_o`=0 and `lowest_o`=0.
- R2: A load captures `mask_i`, resets the lower bound to 0 and the upper bound to 16, and clears `idx_valid_o`. The summary outputs show the new mask from the next cycle onward.
- R3: A forward strobe returns, on the next cycle, the lowest set bit at or above the lower bound and below the upper bound. `idx_valid_o` is high for exactly that one cycle, and the lower bound moves to one past the returned bit.
- R4: A backward strobe returns, on the next cycle, the highest set bit in the same window. The upper bound moves down to the returned bit.
- R5: Under any mix of forward and backward steps, each set bit is returned exactly once, and the lower bound never exceeds the upper bound.
- R6: `done_o` is 1 exactly when no set bit remains in the window. A step taken while `done_o` is 1 gives `idx_valid_o`=0 on the next cycle.
- R7: `count_o` is the number of set bits in the captured mask.
- R8: `empty_o` is 1 exactly when the captured mask is zero.
- R9: `lowest_o` is the index of the lowest set bit of the captured mask, which is the index the first forward step after a load returns. It is 0 when the mask is empty.
- R10: `has_sp_o`, `has_lr_o` and `has_pc_o` equal bits 13, 14 and 15 of the captured mask.
- R11: A load in the same cycle as a step takes priority: the step is dropped, and `idx_valid_o` is 0 on the next cycle.
- R12: When both strobes arrive in the same cycle, only the forward step is served, and the backward strobe leaves the upper bound unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture `mask_i` and restart the walk |
| mask_i | input | 16 | Register-list mask, bit i = register i |
| step_up_i | input | 1 | Return the next register from the low end |
| step_down_i | input | 1 | Return the next register from the high end |
| idx_o | output | 4 | Returned register index |
| idx_valid_o | output | 1 | `idx_o` holds a valid index this cycle |
| done_o | output | 1 | No register remains to be returned |
| count_o | output | 5 | Number of set bits in the captured mask |
| empty_o | output | 1 | Captured mask is zero |
| lowest_o | output | 4 | Lowest set index of the captured mask |
| has_sp_o | output | 1 | Bit 13 of the captured mask |
| has_lr_o | output | 1 | Bit 14 of the captured mask |
| has_pc_o | output | 1 | Bit 15 of the captured mask |

## Verification
The walks use alternating-bit masks (0xAAAA, 0x5555), half masks (0x00FF, 0xFF00), a full mask, a single bit, and a zero mask. The alternating masks show whether the encoder skips clear bits rather than simply counting up or down. The half masks show whether the window bounds are applied at the correct end. Interleaved forward and backward patterns are compared against an independent cursor model. They show whether the two bounds stay consistent, so that no register is returned twice or skipped. Dedicated cases cover both strobes in one cycle and a load arriving together with a step, which show how the block resolves these collisions.

// File: rtl/reglist_pkg.sv
package reglist_pkg;
  localparam int unsigned RL_WIDTH  = 16;
  localparam int unsigned RL_SP_BIT = 13;
  localparam int unsigned RL_LR_BIT = 14;
  localparam int unsigned RL_PC_BIT = 15;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/rl_window.sv
module rl_window #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned CW    = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] bits_i,
  input  logic [CW-1:0]    lo_i,
  input  logic [CW-1:0]    hi_x_i,
  output logic [WIDTH-1:0] win_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign win_o[i] = bits_i[i] & (lo_i <= CW'(i)) & (CW'(i) < hi_x_i);
  end
endmodule

// File: rtl/rl_prio.sv
module rl_prio #(
  parameter int unsigned WIDTH    = 16,
  parameter int unsigned IDXW     = $clog2(WIDTH),
  parameter bit          FROM_TOP = 1'b0
) (
  input  logic [WIDTH-1:0] bits_i,
  output logic             found_o,
  output logic [IDXW-1:0]  idx_o
);
  assign found_o = |bits_i;

  if (FROM_TOP) begin : g_msb
    always_comb begin
      idx_o = '0;
      for (int i = 0; i < int'(WIDTH); i++) begin
        if (bits_i[i]) idx_o = IDXW'(i);
      end
    end
  end else begin : g_lsb
    always_comb begin
      idx_o = '0;
      for (int i = int'(WIDTH) - 1; i >= 0; i--) begin
        if (bits_i[i]) idx_o = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/rl_summary.sv
module rl_summary #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned IDXW  = $clog2(WIDTH),
  parameter int unsigned NW    = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] mask_i,
  output logic [NW-1:0]    count_o,
  output logic             empty_o,
  output logic [IDXW-1:0]  lowest_o,
  output logic             has_sp_o,
  output logic             has_lr_o,
  output logic             has_pc_o
);
  logic unused_found;

  always_comb begin
    count_o = '0;
    for (int i = 0; i < int'(WIDTH); i++) begin
      count_o = count_o + NW'(mask_i[i]);
    end
  end

  assign empty_o = ~|mask_i;

  rl_prio #(.WIDTH(WIDTH), .IDXW(IDXW), .FROM_TOP(1'b0)) u_low (
    .bits_i  (mask_i),
    .found_o (unused_found),
    .idx_o   (lowest_o)
  );

  assign has_sp_o = mask_i[reglist_pkg::RL_SP_BIT];
  assign has_lr_o = mask_i[reglist_pkg::RL_LR_BIT];
  assign has_pc_o = mask_i[reglist_pkg::RL_PC_BIT];
endmodule

// File: rtl/reglist_walker.sv
module reglist_walker #(
  parameter int unsigned WIDTH = reglist_pkg::RL_WIDTH,
  localparam int unsigned IDXW = $clog2(WIDTH),
  localparam int unsigned CW   = IDXW + 1,
  localparam int unsigned NW   = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic             step_up_i,
  input  logic             step_down_i,
  output logic [IDXW-1:0]  idx_o,
  output logic             idx_valid_o,
  output logic             done_o,
  output logic [NW-1:0]    count_o,
  output logic             empty_o,
  output logic [IDXW-1:0]  lowest_o,
  output logic             has_sp_o,
  output logic             has_lr_o,
  output logic             has_pc_o
);
  import reglist_pkg::*;

  logic [WIDTH-1:0] mask_q;
  logic [CW-1:0]    fwd_q;
  logic [CW-1:0]    bwdx_q;
  logic [IDXW-1:0]  idx_q;
  logic             vld_q;
  logic [WIDTH-1:0] win;
  logic             lo_found, hi_found;
  logic [IDXW-1:0]  lo_idx, hi_idx;
  step_e            step_sel;

  rl_window #(.WIDTH(WIDTH), .CW(CW)) u_window (
    .bits_i (mask_q),
    .lo_i   (fwd_q),
    .hi_x_i (bwdx_q),
    .win_o  (win)
  );

  rl_prio #(.WIDTH(WIDTH), .IDXW(IDXW), .FROM_TOP(1'b0)) u_up (
    .bits_i  (win),
    .found_o (lo_found),
    .idx_o   (lo_idx)
  );

  rl_prio #(.WIDTH(WIDTH), .IDXW(IDXW), .FROM_TOP(1'b1)) u_down (
    .bits_i  (win),
    .found_o (hi_found),
    .idx_o   (hi_idx)
  );

  rl_summary #(.WIDTH(WIDTH), .IDXW(IDXW), .NW(NW)) u_summary (
    .mask_i   (mask_q),
    .count_o  (count_o),
    .empty_o  (empty_o),
    .lowest_o (lowest_o),
    .has_sp_o (has_sp_o),
    .has_lr_o (has_lr_o),
    .has_pc_o (has_pc_o)
  );

  always_comb begin
    if (step_up_i)        step_sel = STEP_UP;
    else if (step_down_i) step_sel = STEP_DOWN;
    else                  step_sel = STEP_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      fwd_q  <= '0;
      bwdx_q <= '0;
      idx_q  <= '0;
      vld_q  <= 1'b0;
    end else if (load_i) begin
      mask_q <= mask_i;
      fwd_q  <= '0;
      bwdx_q <= CW'(WIDTH);
      vld_q  <= 1'b0;
    end else begin
      unique case (step_sel)
        STEP_UP: begin
          if (lo_found) begin
            idx_q <= lo_idx;
            vld_q <= 1'b1;
            fwd_q <= CW'(lo_idx) + CW'(1);
          end else begin
            vld_q <= 1'b0;
            fwd_q <= bwdx_q;
          end
        end
        STEP_DOWN: begin
          if (hi_found) begin
            idx_q  <= hi_idx;
            vld_q  <= 1'b1;
            bwdx_q <= CW'(hi_idx);
          end else begin
            vld_q  <= 1'b0;
            bwdx_q <= fwd_q;
          end
        end
        default: vld_q <= 1'b0;
      endcase
    end
  end

  assign idx_o       = idx_q;
  assign idx_valid_o = vld_q;
  assign done_o      = ~lo_found;
endmodule

// File: rtl/rl_checker.sv
module rl_checker #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned IDXW  = $clog2(WIDTH),
  parameter int unsigned CW    = IDXW + 1,
  parameter int unsigned NW    = $clog2(WIDTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic             step_up_i,
  input logic             step_down_i,
  input logic [IDXW-1:0]  idx_o,
  input logic             idx_valid_o,
  input logic             done_o,
  input logic [NW-1:0]    count_o,
  input logic             empty_o,
  input logic             has_pc_o,
  input logic [WIDTH-1:0] mask_q,
  input logic [CW-1:0]    fwd_q,
  input logic [CW-1:0]    bwdx_q
);
  assert_cursor_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_q <= bwdx_q);

  assert_cursor_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (fwd_q >= $past(fwd_q)) && (bwdx_q <= $past(bwdx_q)));

  assert_load_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !idx_valid_o);

  assert_idx_in_list_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid_o |-> mask_q[idx_o]);

  assert_valid_needs_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid_o |-> $past(step_up_i || step_down_i));

  assert_exhausted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> !idx_valid_o);

  assert_empty_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o == (count_o == '0));

  assert_pc_not_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    has_pc_o |-> !empty_o);
endmodule

bind reglist_walker rl_checker #(.WIDTH(WIDTH)) u_rl_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_i      (load_i),
  .step_up_i   (step_up_i),
  .step_down_i (step_down_i),
  .idx_o       (idx_o),
  .idx_valid_o (idx_valid_o),
  .done_o      (done_o),
  .count_o     (count_o),
  .empty_o     (empty_o),
  .has_pc_o    (has_pc_o),
  .mask_q      (mask_q),
  .fwd_q       (fwd_q),
  .bwdx_q      (bwdx_q)
);

// File: tb/reglist_walker_bench.sv
module reglist_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [15:0] mask_i = '0;
  logic        step_up_i = 1'b0;
  logic        step_down_i = 1'b0;
  logic [3:0]  idx_o;
  logic        idx_valid_o;
  logic        done_o;
  logic [4:0]  count_o;
  logic        empty_o;
  logic [3:0]  lowest_o;
  logic        has_sp_o, has_lr_o, has_pc_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  reglist_walker u_reglist_walker (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .mask_i(mask_i),
    .step_up_i(step_up_i), .step_down_i(step_down_i),
    .idx_o(idx_o), .idx_valid_o(idx_valid_o), .done_o(done_o),
    .count_o(count_o), .empty_o(empty_o), .lowest_o(lowest_o),
    .has_sp_o(has_sp_o), .has_lr_o(has_lr_o), .has_pc_o(has_pc_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [15:0] m, input bit up, input bit dn);
    @(negedge clk);
    load_i = 1'b1; mask_i = m; step_up_i = up; step_down_i = dn;
    @(negedge clk);
    load_i = 1'b0; step_up_i = 1'b0; step_down_i = 1'b0;
  endtask

  task automatic do_step(input bit up, input bit dn);
    @(negedge clk);
    step_up_i = up; step_down_i = dn;
    @(negedge clk);
    step_up_i = 1'b0; step_down_i = 1'b0;
  endtask

  function automatic int popc(input logic [15:0] m);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(m[i]);
    return n;
  endfunction

  task automatic t_reset();
    chk(idx_valid_o == 1'b0, "R1 valid", int'(idx_valid_o), 0);
    chk(done_o == 1'b1, "R1 done", int'(done_o), 1);
    chk(empty_o == 1'b1, "R1 empty", int'(empty_o), 1);
    chk(count_o == 5'd0, "R1 count", int'(count_o), 0);
    chk(lowest_o == 4'd0, "R1 lowest", int'(lowest_o), 0);
  endtask

  task automatic t_summary(input logic [15:0] m);
    int lo = 0;
    for (int i = 15; i >= 0; i--) if (m[i]) lo = i;
    do_load(m, 1'b0, 1'b0);
    chk(idx_valid_o == 1'b0, "R2 valid after load", int'(idx_valid_o), 0);
    chk(int'(count_o) == popc(m), "R7 count", int'(count_o), popc(m));
    chk(empty_o == (m == 16'h0), "R8 empty", int'(empty_o), int'(m == 16'h0));
    chk(int'(lowest_o) == lo, "R9 lowest", int'(lowest_o), lo);
    chk(has_sp_o == m[13] && has_lr_o == m[14] && has_pc_o == m[15], "R10 sp/lr/pc",
        int'({has_pc_o, has_lr_o, has_sp_o}), int'(m[15:13]));
  endtask

  // pat bit k = 1 means step k is backward, 0 means forward
  task automatic t_walk(input logic [15:0] m, input logic [31:0] pat, input string req);
    int lo = 0;
    int hx = 16;
    logic [15:0] seen = '0;
    int n = popc(m) + 2;
    do_load(m, 1'b0, 1'b0);
    for (int k = 0; k < n; k++) begin
      int e = -1;
      if (!pat[k]) begin
        for (int i = hx - 1; i >= lo; i--) if (m[i]) e = i;
      end else begin
        for (int i = lo; i < hx; i++) if (m[i]) e = i;
      end
      do_step(!pat[k], pat[k]);
      if (e < 0) begin
        chk(idx_valid_o == 1'b0, {req, " R6 no index when exhausted"}, int'(idx_valid_o), 0);
        if (!pat[k]) lo = hx; else hx = lo;
      end else begin
        chk(idx_valid_o == 1'b1 && int'(idx_o) == e, req,
            idx_valid_o ? int'(idx_o) : -1, e);
        if (idx_valid_o) seen[idx_o] = 1'b1;
        if (!pat[k]) lo = e + 1; else hx = e;
      end
      begin
        bit rem = 1'b0;
        for (int i = lo; i < hx; i++) if (m[i]) rem = 1'b1;
        chk(done_o == !rem, "R6 done", int'(done_o), int'(!rem));
      end
    end
    chk(seen == m, "R5 each bit once", int'(seen), int'(m));
  endtask

  task automatic t_pulse();
    do_load(16'h0300, 1'b0, 1'b0);
    do_step(1'b1, 1'b0);
    chk(idx_valid_o && idx_o == 4'd8, "R3 first index", int'(idx_o), 8);
    @(negedge clk);
    chk(idx_valid_o == 1'b0, "R3 one-cycle pulse", int'(idx_valid_o), 0);
  endtask

  task automatic t_both();
    do_load(16'h8101, 1'b0, 1'b0);
    do_step(1'b1, 1'b1);
    chk(idx_valid_o && idx_o == 4'd0, "R12 forward wins", int'(idx_o), 0);
    do_step(1'b0, 1'b1);
    chk(idx_valid_o && idx_o == 4'd15, "R12 upper bound untouched", int'(idx_o), 15);
    do_step(1'b1, 1'b0);
    chk(idx_valid_o && idx_o == 4'd8, "R12 middle", int'(idx_o), 8);
    chk(done_o == 1'b1, "R12 done", int'(done_o), 1);
  endtask

  task automatic t_load_prio();
    do_load(16'h00F0, 1'b0, 1'b0);
    do_step(1'b1, 1'b0);
    do_load(16'h0C00, 1'b1, 1'b0);
    chk(idx_valid_o == 1'b0, "R11 step dropped", int'(idx_valid_o), 0);
    chk(count_o == 5'd2, "R11 new mask", int'(count_o), 2);
    do_step(1'b1, 1'b0);
    chk(idx_valid_o && idx_o == 4'd10, "R11 walk restarted", int'(idx_o), 10);
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_summary(16'hAAAA);
    t_summary(16'h5555);
    t_summary(16'hE000);
    t_summary(16'h0001);
    t_summary(16'h0000);
    t_summary(16'h6010);
    t_walk(16'hAAAA, 32'h0, "R3 ascending 0xAAAA");
    t_walk(16'h00FF, 32'h0, "R3 ascending 0x00FF");
    t_walk(16'h5555, 32'hFFFFFFFF, "R4 descending 0x5555");
    t_walk(16'hFF00, 32'hFFFFFFFF, "R4 descending 0xFF00");
    t_walk(16'hFFFF, 32'h55555555, "R5 interleave full");
    t_walk(16'h9A63, 32'h0000F0CC, "R5 interleave mixed");
    t_walk(16'h0040, 32'h00000002, "R5 single bit");
    t_walk(16'h0000, 32'h00000002, "R6 empty mask");
    t_pulse();
    t_both();
    t_load_prio();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    #800000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule